// File: doc/BRIEF.md
# Card Status-Change Interrupt Controller

This block gathers interrupt events for a removable-card socket controller and drives one host interrupt line. Five card status inputs come in asynchronously: card detect, write protect, ready, battery-low 2 and battery-low 1. Each is synchronized and edge-detected. Any change that is not masked raises a summary status-change flag, and every change is also latched per source in a status byte. Single-cycle event pulses from neighbouring logic (I/O check, error, programming timeout, interlock change, stop-CPU) set their own flags directly.

Software reaches four byte-wide registers through a simple write-strobe port with a combinational read path: the flag register, the enable register, the change-mask register and the latched-status register. Writes to the flag register carry a two-bit qualifier in their low bits. It selects set-only, clear-only or direct load. The interrupt pin has four drive modes, presented as a drive-enable and a level output so that the pad can be built outside the block.

Top module: `cscirq_top`

## Requirements
- R1: After reset all four registers read 0x00 and the drive-enable output `irq_oe_o` is low.
- R2: A one-cycle pulse on an event input sets its flag in the flag register (address 0), readable after the next rising edge: I/O check bit 7, error bit 5, programming timeout bit 4, interlock change bit 3, stop-CPU bit 2.
- R3: A flag-register write with qualifier bits [1:0] = 2'b10 sets every flag whose written bit is 1 and leaves the other flags alone.
- R4: A flag-register write with qualifier 2'b01 clears every flag whose written bit is 1 and leaves the other flags alone.
- R5: Qualifier 2'b11 loads bits 7:2 directly. Qualifier 2'b00 changes nothing. Bits 1:0 of the flag register always read 0.
- R6: When a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R7: The status inputs map to status positions 7..3 as card detect, write protect, ready, battery-low 2, battery-low 1. A change on an input becomes visible in the flag register (bit 6) and the latched-status register (address 3) after the third rising edge following the change, and not after the second.
- R8: Both the rising and the falling transition of the ready input raise the status-change flag.
- R9: The mask register (address 2, bits 7..3, same order; bits 2:0 read 0) suppresses the status-change flag for a masked source. The latched bit of that source is still set.
- R10: Writing 1 to a latched-status bit clears it. Writing 0 leaves it unchanged.
- R11: The enable register (address 1) reads bits 7 and 2 as 0. Bits 6, 5, 4, 3 enable the status-change, error, timeout and interlock flags. The interrupt is asserted only while an enabled flag is set, so the I/O check and stop-CPU flags never assert it.
- R12: Pin mode (enable bits 1:0): 0 leaves `irq_oe_o` low. 1 drives (oe=1, level=0) only while the interrupt is asserted. 2 drives constantly, with level low when asserted. 3 drives constantly, with level high when asserted.
- R13: The status-change flag stays set after the latched status bits are cleared, until software clears it through the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one write per cycle |
| reg_addr | input | ADDR_W | Register select: 0 flags, 1 enable, 2 mask, 3 latched status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| card_sts_i | input | 5 | Asynchronous status inputs [4]=detect, [3]=write protect, [2]=ready, [1]=battery-low 2, [0]=battery-low 1 |
| ev_iochk_i | input | 1 | I/O check event pulse |
| ev_err_i | input | 1 | Error event pulse |
| ev_prog_i | input | 1 | Programming timeout event pulse |
| ev_ilock_i | input | 1 | Interlock change event pulse |
| ev_stop_i | input | 1 | Stop-CPU event pulse |
| irq_oe_o | output | 1 | Interrupt pad drive enable |
| irq_lvl_o | output | 1 | Interrupt pad level while driven |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer and a combinational pin stage. With these settings the three-edge latency from a status input to the registers can be predicted exactly, and the bench samples one edge early to show the change is not yet visible. The same settings let every pin-mode change be observed on the edge right after the write. The registered pin variant and deeper synchronizers are elaboration options that this bench does not exercise.

// File: rtl/cscirq_pkg.sv
package cscirq_pkg;
   localparam int unsigned REG_W   = 8;
   localparam int unsigned NUM_STS = 5;
   localparam int unsigned STS_LSB = 3;

   localparam int unsigned F_IOCHK = 7;
   localparam int unsigned F_STCHG = 6;
   localparam int unsigned F_ERR   = 5;
   localparam int unsigned F_PROG  = 4;
   localparam int unsigned F_ILOCK = 3;
   localparam int unsigned F_STOP  = 2;

   localparam int unsigned A_FLAGS = 0;
   localparam int unsigned A_ENA   = 1;
   localparam int unsigned A_MASK  = 2;
   localparam int unsigned A_LATCH = 3;

   localparam logic [REG_W-1:0] FLAG_KEEP   = 8'hFC;
   localparam logic [REG_W-1:0] ENA_KEEP    = 8'h7B;
   localparam logic [REG_W-1:0] STS_KEEP    = 8'hF8;
   localparam logic [REG_W-1:0] IRQ_SOURCES = 8'h78;

   typedef enum logic [1:0] {
      PIN_HIZ      = 2'd0,
      PIN_OD_LOW   = 2'd1,
      PIN_DRV_LOW  = 2'd2,
      PIN_DRV_HIGH = 2'd3
   } pin_mode_e;

   typedef enum logic [1:0] {
      WQ_NONE  = 2'd0,
      WQ_CLEAR = 2'd1,
      WQ_SET   = 2'd2,
      WQ_LOAD  = 2'd3
   } wqual_e;
endpackage

// File: rtl/cscirq_sync_edge.sv
module cscirq_sync_edge #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] chg_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cscirq_sync_edge: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cscirq_sync_edge: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] shreg;
      logic              prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shreg  <= '0;
            prev_q <= 1'b0;
         end else begin
            shreg  <= {shreg[STAGES-2:0], raw_i[b]};
            prev_q <= shreg[STAGES-1];
         end
      end

      assign chg_o[b] = shreg[STAGES-1] ^ prev_q;
   end
endmodule

// File: rtl/cscirq_flag_reg.sv
module cscirq_flag_reg
   import cscirq_pkg::*;
#(
   parameter int unsigned     W    = 8,
   parameter logic [W-1:0]    KEEP = 8'hFC
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] set_i,
   output logic [W-1:0] q_o
);
   if (W < 3) begin : g_bad_w
      $error("cscirq_flag_reg: W must leave room for the qualifier bits");
   end

   wqual_e       qual;
   logic [W-1:0] sw_next;
   logic [W-1:0] q_d;

   assign qual = wqual_e'(wdata_i[1:0]);

   always_comb begin
      sw_next = q_o;
      if (wr_en_i) begin
         unique case (qual)
            WQ_CLEAR: sw_next = q_o & ~wdata_i;
            WQ_SET:   sw_next = q_o | wdata_i;
            WQ_LOAD:  sw_next = wdata_i;
            default:  sw_next = q_o;
         endcase
      end
      q_d = (sw_next | set_i) & KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= q_d;
   end

   for (genvar i = 0; i < W; i++) begin : g_chk
      if (KEEP[i]) begin : g_live
         // R2
         hw_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
         // R4
         sw_clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && qual == WQ_CLEAR && wdata_i[i] && !set_i[i]) |=> !q_o[i]);
         // R3
         sw_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && qual == WQ_SET && wdata_i[i]) |=> q_o[i]);
      end
   end
endmodule

// File: rtl/cscirq_w1c_reg.sv
module cscirq_w1c_reg #(
   parameter int unsigned  W    = 8,
   parameter logic [W-1:0] KEEP = 8'hF8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en_i,
   input  logic [W-1:0] wdata_i,
   input  logic [W-1:0] set_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] clr;
   assign clr = wr_en_i ? wdata_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= ((q_o & ~clr) | set_i) & KEEP;
   end

   for (genvar i = 0; i < W; i++) begin : g_chk
      if (KEEP[i]) begin : g_live
         // R10
         w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wdata_i[i] && !set_i[i]) |=> !q_o[i]);
         // R10
         w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[i] && !(wr_en_i && wdata_i[i])) |=> q_o[i]);
      end
   end
endmodule

// File: rtl/cscirq_pin_drive.sv
module cscirq_pin_drive
   import cscirq_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      irq_i,
   input  pin_mode_e mode_i,
   output logic      oe_o,
   output logic      lvl_o
);
   logic oe_c;
   logic lvl_c;

   always_comb begin
      unique case (mode_i)
         PIN_HIZ:      begin oe_c = 1'b0;  lvl_c = 1'b0;   end
         PIN_OD_LOW:   begin oe_c = irq_i; lvl_c = 1'b0;   end
         PIN_DRV_LOW:  begin oe_c = 1'b1;  lvl_c = ~irq_i; end
         default:      begin oe_c = 1'b1;  lvl_c = irq_i;  end
      endcase
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            oe_o  <= 1'b0;
            lvl_o <= 1'b0;
         end else begin
            oe_o  <= oe_c;
            lvl_o <= lvl_c;
         end
      end
      // R12
      hiz_idle_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i == PIN_HIZ) |=> !oe_o);
   end else begin : g_comb
      assign oe_o  = oe_c;
      assign lvl_o = lvl_c;
      // R12
      hiz_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i == PIN_HIZ) |-> !oe_o);
      // R12
      od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i == PIN_OD_LOW && !irq_i) |-> !oe_o);
   end
endmodule

// File: rtl/cscirq_top.sv
module cscirq_top
   import cscirq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PIN_REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [4:0]        card_sts_i,
   input  logic              ev_iochk_i,
   input  logic              ev_err_i,
   input  logic              ev_prog_i,
   input  logic              ev_ilock_i,
   input  logic              ev_stop_i,
   output logic              irq_oe_o,
   output logic              irq_lvl_o
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("cscirq_top: ADDR_W must reach four registers");
   end
   if (STS_LSB + NUM_STS != REG_W) begin : g_bad_layout
      $error("cscirq_top: status sources must fill the top of the byte");
   end

   logic              sel_flags, sel_ena, sel_mask, sel_latch;
   logic [NUM_STS-1:0] sts_chg;
   logic [NUM_STS-1:0] unmasked_chg;
   logic [REG_W-1:0]  flags_q, ena_q, mask_q, latch_q;
   logic [REG_W-1:0]  flag_set, latch_set;
   logic              irq_active;

   assign sel_flags = reg_wr_en && (reg_addr == ADDR_W'(A_FLAGS));
   assign sel_ena   = reg_wr_en && (reg_addr == ADDR_W'(A_ENA));
   assign sel_mask  = reg_wr_en && (reg_addr == ADDR_W'(A_MASK));
   assign sel_latch = reg_wr_en && (reg_addr == ADDR_W'(A_LATCH));

   cscirq_sync_edge #(
      .WIDTH  (NUM_STS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (card_sts_i),
      .chg_o (sts_chg)
   );

   assign unmasked_chg = sts_chg & ~mask_q[REG_W-1:STS_LSB];

   always_comb begin
      flag_set          = '0;
      flag_set[F_IOCHK] = ev_iochk_i;
      flag_set[F_STCHG] = |unmasked_chg;
      flag_set[F_ERR]   = ev_err_i;
      flag_set[F_PROG]  = ev_prog_i;
      flag_set[F_ILOCK] = ev_ilock_i;
      flag_set[F_STOP]  = ev_stop_i;
      latch_set         = {sts_chg, {STS_LSB{1'b0}}};
   end

   cscirq_flag_reg #(
      .W    (REG_W),
      .KEEP (FLAG_KEEP)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (sel_flags),
      .wdata_i (reg_wdata),
      .set_i   (flag_set),
      .q_o     (flags_q)
   );

   cscirq_w1c_reg #(
      .W    (REG_W),
      .KEEP (STS_KEEP)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (sel_latch),
      .wdata_i (reg_wdata),
      .set_i   (latch_set),
      .q_o     (latch_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q  <= '0;
         mask_q <= '0;
      end else begin
         if (sel_ena)  ena_q  <= reg_wdata & ENA_KEEP;
         if (sel_mask) mask_q <= reg_wdata & STS_KEEP;
      end
   end

   assign irq_active = |(flags_q & ena_q & IRQ_SOURCES);

   cscirq_pin_drive #(
      .REG_OUT (PIN_REG_OUT)
   ) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_i  (irq_active),
      .mode_i (pin_mode_e'(ena_q[1:0])),
      .oe_o   (irq_oe_o),
      .lvl_o  (irq_lvl_o)
   );

   always_comb begin
      unique case (reg_addr)
         ADDR_W'(A_FLAGS): reg_rdata = flags_q;
         ADDR_W'(A_ENA):   reg_rdata = ena_q;
         ADDR_W'(A_MASK):  reg_rdata = mask_q;
         ADDR_W'(A_LATCH): reg_rdata = latch_q;
         default:          reg_rdata = '0;
      endcase
   end

   for (genvar s = 0; s < NUM_STS; s++) begin : g_src_chk
      // R7
      latch_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(latch_q[STS_LSB+s]) |-> $past(sts_chg[s]));
   end

   // R9
   stchg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[F_STCHG]) |->
         ($past(|unmasked_chg) || $past(sel_flags && reg_wdata[F_STCHG] && reg_wdata[1])));

   // R11
   ena_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_q[7] == 1'b0) && (ena_q[2] == 1'b0));
endmodule

// File: tb/cscirq_top_tb.sv
module cscirq_top_tb;
   logic       clk;
   logic       rst_n;
   logic       wr_en;
   logic [1:0] addr;
   logic [7:0] wdata;
   logic [7:0] rdata;
   logic [4:0] sts;
   logic       ev_iochk, ev_err, ev_prog, ev_ilock, ev_stop;
   logic       oe, lvl;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   cscirq_top u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr_en  (wr_en),
      .reg_addr   (addr),
      .reg_wdata  (wdata),
      .reg_rdata  (rdata),
      .card_sts_i (sts),
      .ev_iochk_i (ev_iochk),
      .ev_err_i   (ev_err),
      .ev_prog_i  (ev_prog),
      .ev_ilock_i (ev_ilock),
      .ev_stop_i  (ev_stop),
      .irq_oe_o   (oe),
      .irq_lvl_o  (lvl)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
      addr = a;
      #1;
      chk(req, $sformatf("reg%0d", a), rdata, exp);
   endtask

   task automatic pin_chk(input string req, input logic exp_oe, input logic exp_lvl);
      chk(req, "oe", {7'b0, oe}, {7'b0, exp_oe});
      chk(req, "lvl", {7'b0, lvl}, {7'b0, exp_lvl});
   endtask

   // events order: {iochk, err, prog, ilock, stop}
   task automatic pulse(input logic [4:0] ev);
      @(negedge clk);
      {ev_iochk, ev_err, ev_prog, ev_ilock, ev_stop} = ev;
      @(negedge clk);
      {ev_iochk, ev_err, ev_prog, ev_ilock, ev_stop} = '0;
   endtask

   task automatic sts_step(input string req, input logic [4:0] v,
                           input logic [7:0] exp_flags, input logic [7:0] exp_latch);
      @(negedge clk);
      sts = v;
      @(negedge clk);
      @(negedge clk);
      rd_chk(req, 2'd0, 8'h00);
      rd_chk(req, 2'd3, 8'h00);
      @(negedge clk);
      rd_chk(req, 2'd0, exp_flags);
      rd_chk(req, 2'd3, exp_latch);
   endtask

   task automatic t_reset();
      rd_chk("R1", 2'd0, 8'h00);
      rd_chk("R1", 2'd1, 8'h00);
      rd_chk("R1", 2'd2, 8'h00);
      rd_chk("R1", 2'd3, 8'h00);
      chk("R1", "oe", {7'b0, oe}, 8'h00);
   endtask

   task automatic t_events();
      pulse(5'b01000);
      rd_chk("R2", 2'd0, 8'h20);
      pulse(5'b11111);
      rd_chk("R2", 2'd0, 8'hBC);
      wr(2'd0, 8'hBD);
      rd_chk("R4", 2'd0, 8'h00);
   endtask

   task automatic t_qualifiers();
      wr(2'd0, 8'h52);
      rd_chk("R3", 2'd0, 8'h50);
      wr(2'd0, 8'h22);
      rd_chk("R3", 2'd0, 8'h70);
      wr(2'd0, 8'h21);
      rd_chk("R4", 2'd0, 8'h50);
      wr(2'd0, 8'hAC);
      rd_chk("R5", 2'd0, 8'h50);
      wr(2'd0, 8'h8B);
      rd_chk("R5", 2'd0, 8'h88);
      wr(2'd0, 8'h03);
      rd_chk("R5", 2'd0, 8'h00);
   endtask

   task automatic t_race();
      @(negedge clk);
      ev_prog = 1'b1; wr_en = 1'b1; addr = 2'd0; wdata = 8'h31;
      @(negedge clk);
      ev_prog = 1'b0; wr_en = 1'b0;
      rd_chk("R6", 2'd0, 8'h10);
      wr(2'd0, 8'h03);
   endtask

   task automatic t_stchg();
      sts_step("R7", 5'b10000, 8'h40, 8'h80);
      wr(2'd3, 8'h00);
      rd_chk("R10", 2'd3, 8'h80);
      wr(2'd3, 8'h80);
      rd_chk("R10", 2'd3, 8'h00);
      rd_chk("R13", 2'd0, 8'h40);
      wr(2'd0, 8'h41);
      rd_chk("R13", 2'd0, 8'h00);
   endtask

   task automatic t_ready();
      sts_step("R8", 5'b10100, 8'h40, 8'h20);
      wr(2'd3, 8'hF8);
      wr(2'd0, 8'h03);
      sts_step("R8", 5'b10000, 8'h40, 8'h20);
      wr(2'd3, 8'hF8);
      wr(2'd0, 8'h03);
   endtask

   task automatic t_mask();
      wr(2'd2, 8'h47);
      rd_chk("R9", 2'd2, 8'h40);
      sts_step("R9", 5'b11000, 8'h00, 8'h40);
      wr(2'd3, 8'hF8);
      sts_step("R7", 5'b11011, 8'h40, 8'h18);
      wr(2'd3, 8'hF8);
      wr(2'd0, 8'h03);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_irq();
      wr(2'd1, 8'hFF);
      rd_chk("R11", 2'd1, 8'h7B);
      pulse(5'b10001);
      rd_chk("R11", 2'd0, 8'h84);
      pin_chk("R11", 1'b1, 1'b0);
      pulse(5'b00010);
      pin_chk("R12", 1'b1, 1'b1);
      wr(2'd1, 8'h0A);
      pin_chk("R12", 1'b1, 1'b0);
      wr(2'd1, 8'h09);
      pin_chk("R12", 1'b1, 1'b0);
      wr(2'd1, 8'h08);
      pin_chk("R12", 1'b0, 1'b0);
      wr(2'd1, 8'h03);
      pin_chk("R11", 1'b1, 1'b0);
      wr(2'd1, 8'h01);
      pin_chk("R12", 1'b0, 1'b0);
      wr(2'd1, 8'h23);
      pin_chk("R11", 1'b1, 1'b0);
      pulse(5'b01000);
      pin_chk("R11", 1'b1, 1'b1);
      wr(2'd0, 8'h03);
      pin_chk("R11", 1'b1, 1'b0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; sts = '0;
      {ev_iochk, ev_err, ev_prog, ev_ilock, ev_stop} = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_events();
      t_qualifiers();
      t_race();
      t_stchg();
      t_ready();
      t_mask();
      t_irq();
      done = 1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end
endmodule